// File: doc/BRIEF.md
# Synchronous Burst Pipelined SRAM

A single-port synchronous static memory with a parameterised depth and a 32-bit word, split into four byte lanes. Address, data and every command input are sampled on the rising clock edge. Two address strobes can open a burst at an external address. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write inputs. Once a burst is open, an advance input either steps a two-bit burst counter or holds the current address, so wait states can be inserted into reads and writes alike. The burst order is linear or interleaved, chosen by an asynchronous mode input.

Three chip selects qualify every burst start. A start with a bad select closes the burst, and later step or hold cycles do nothing until a new valid start. Read data leaves through a one-stage output register. It appears on `rdata` with `rvalid` high one edge after the read address was registered. An asynchronous output enable masks the result. A sleep input parks the block in a power-down state. After sleep is released, a three-edge wake window must pass before commands are accepted again, and the stored data is kept throughout.

A controller state machine has four states: `PS_DOWN` (asleep), `PS_WAKE` (counting wake edges), `PS_IDLE` (awake, no burst open) and `PS_BURST` (burst open). Its transitions are:
- sleep high moves any state to `PS_DOWN`;
- `PS_DOWN` goes to `PS_WAKE` on the first edge with sleep low;
- `PS_WAKE` goes to `PS_IDLE` when the wake count completes;
- a valid start moves `PS_IDLE` or `PS_BURST` to `PS_BURST`;
- a deselecting start moves `PS_IDLE` or `PS_BURST` to `PS_IDLE`;
- step and hold cycles leave the state unchanged.

Each edge's command is one of these cycle kinds: `CY_START`, `CY_DESEL`, `CY_NEXT` and `CY_HOLD`.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rvalid` is low, `rdata` is zero, and the block is awake with no burst open, so a step or hold cycle returns nothing.
- R2: A burst start is deselecting when any chip select is wrong. The select is valid only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. A deselecting start performs no read and no write, and later step or hold cycles do nothing until a valid start.
- R3: While `sel_a_n` is 1, `cpu_strb_n` is ignored. With `ctl_strb_n` also 1, the edge is a step cycle when `step_n` is 0 and a hold cycle when `step_n` is 1.
- R4: `cpu_strb_n` = 0 with `sel_a_n` = 0 and a valid select opens a read burst at `addr`, whatever the write inputs. To write that address, a hold cycle with write inputs must follow.
- R5: `ctl_strb_n` = 0, when `cpu_strb_n` is 1 or ignored, opens a burst at `addr` with a valid select. The opening cycle is a write when any byte lane is enabled, and a read otherwise.
- R6: With both strobes high in an open burst, `step_n` = 0 advances the burst counter before the access, and `step_n` = 1 repeats the current address. Either cycle is a write when any lane is enabled, and a read otherwise.
- R7: The burst counter starts at 0 and wraps modulo 4. The two low address bits are (base + count) mod 4 when `lin_order` is 1, and base XOR count when it is 0. The upper address bits stay at the base.
- R8: `all_wr_n` = 0 writes all four lanes. Otherwise lane n (bits 8n+7:8n, lane 0 lowest) is written only when `lane_wr_en_n` = 0 and `lane_sel_n[n]` = 0. With `all_wr_n` and `lane_wr_en_n` both 1, the cycle is a read.
- R9: A read registered at edge k sets `rvalid` and presents the word after edge k+1, with the value stored as of edge k. At all other times `rdata` is zero and `rvalid` is low.
- R10: `out_en_n` = 1 drives `rvalid` low and `rdata` to zero at once, without disturbing the read pipeline.
- R11: An edge with `sleep` = 1 ignores its command, leaves `rvalid` low after that edge, and keeps the memory contents.
- R12: After sleep, the first three edges with `sleep` = 0 ignore their commands. The fourth such edge accepts a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down request, sampled each edge |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Active-low output enable, asynchronous |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor address strobe, opens a read burst |
| ctl_strb_n | input | 1 | Controller address strobe, opens a read or write burst |
| step_n | input | 1 | Burst advance, 0 = next address, 1 = hold |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_en_n | input | 1 | Enables the per-lane write selects |
| lane_sel_n | input | NB (4) | Per-lane write selects, active low |
| addr | input | ADDR_W (6) | External word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
A command presented before edge k changes the memory at edge k if it is a write. If it is a read, it shows up on `rvalid` and `rdata` only after edge k+1. Sleep at edge k clears `rvalid` after that same edge, and `out_en_n` acts without any edge. The bench drives each command on a falling edge and computes the command's result from its own model at that point. It then waits through one more rising edge and compares the outputs on the next falling edge against the result of the command two edges back, gated by the sleep and enable levels of the current command. The wake window is counted in edges with sleep low: three ignored edges, with the fourth accepted.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        PS_DOWN,
        PS_WAKE,
        PS_IDLE,
        PS_BURST
    } pwr_state_e;

    typedef enum logic [2:0] {
        CY_NONE,
        CY_DESEL,
        CY_START,
        CY_NEXT,
        CY_HOLD
    } cyc_kind_e;

endpackage

// File: rtl/burst_sram_lanes.sv
`timescale 1ns/1ps
module burst_sram_lanes #(
    parameter int NB = 4
) (
    input  logic          all_wr_n,
    input  logic          lane_wr_en_n,
    input  logic [NB-1:0] lane_sel_n,
    output logic [NB-1:0] byte_en,
    output logic          wr_any
);

    // global write overrides; otherwise lane select qualified by enable
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign byte_en[g] = !all_wr_n || (!lane_wr_en_n && !lane_sel_n[g]);
    end

    assign wr_any = |byte_en;

endmodule

// File: rtl/burst_sram_agen.sv
`timescale 1ns/1ps
module burst_sram_agen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  base_use;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_use;
    logic [BURST_W-1:0] low_bits;

    always_comb begin
        base_use = load ? ext_addr : base_q;
        if (load) begin
            cnt_use = '0;
        end else if (step) begin
            cnt_use = cnt_q + 1'b1;
        end else begin
            cnt_use = cnt_q;
        end
        if (lin_order) begin
            low_bits = base_use[BURST_W-1:0] + cnt_use;
        end else begin
            low_bits = base_use[BURST_W-1:0] ^ cnt_use;
        end
        cur_addr = {base_use[ADDR_W-1:BURST_W], low_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            base_q <= base_use;
            cnt_q  <= cnt_use;
        end
    end

endmodule

// File: rtl/burst_sram_fsm.sv
`timescale 1ns/1ps
module burst_sram_fsm
    import burst_sram_pkg::*;
#(
    parameter int WAKE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    input  logic cpu_strb_n,
    input  logic ctl_strb_n,
    input  logic step_n,
    input  logic wr_any,
    output logic ag_en,
    output logic ag_load,
    output logic ag_step,
    output logic do_rd,
    output logic do_wr,
    output logic awake
);

    localparam int WK_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYC - 2);

    pwr_state_e st_q, st_d;
    logic [WK_W-1:0] wk_q, wk_d;
    cyc_kind_e cyc;
    logic sel_ok;
    logic via_cpu;

    // command classification
    always_comb begin
        sel_ok  = !sel_a_n && sel_b && !sel_c_n;
        via_cpu = 1'b0;
        if (!sel_a_n && !cpu_strb_n) begin
            via_cpu = 1'b1;
            cyc     = sel_ok ? CY_START : CY_DESEL;
        end else if (!ctl_strb_n) begin
            cyc     = sel_ok ? CY_START : CY_DESEL;
        end else if (!step_n) begin
            cyc     = CY_NEXT;
        end else begin
            cyc     = CY_HOLD;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        wk_d = wk_q;
        unique case (st_q)
            PS_DOWN: begin
                st_d = PS_WAKE;
                wk_d = '0;
            end
            PS_WAKE: begin
                if (wk_q == WK_LAST) begin
                    st_d = PS_IDLE;
                end else begin
                    wk_d = wk_q + 1'b1;
                end
            end
            PS_IDLE, PS_BURST: begin
                if (cyc == CY_START) begin
                    st_d = PS_BURST;
                end else if (cyc == CY_DESEL) begin
                    st_d = PS_IDLE;
                end
            end
            default: st_d = PS_IDLE;
        endcase
        if (sleep) begin
            st_d = PS_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PS_IDLE;
            wk_q <= '0;
        end else begin
            st_q <= st_d;
            wk_q <= wk_d;
        end
    end

    // outputs
    always_comb begin
        ag_en   = 1'b0;
        ag_load = 1'b0;
        ag_step = 1'b0;
        do_rd   = 1'b0;
        do_wr   = 1'b0;
        if (!sleep && (st_q == PS_IDLE || st_q == PS_BURST)) begin
            unique case (cyc)
                CY_START: begin
                    ag_en   = 1'b1;
                    ag_load = 1'b1;
                    do_wr   = !via_cpu && wr_any;
                    do_rd   = via_cpu || !wr_any;
                end
                CY_NEXT, CY_HOLD: begin
                    if (st_q == PS_BURST) begin
                        ag_en   = 1'b1;
                        ag_step = (cyc == CY_NEXT);
                        do_wr   = wr_any;
                        do_rd   = !wr_any;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign awake = (st_q == PS_IDLE) || (st_q == PS_BURST);

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int WAKE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep,
    input  logic                lin_order,
    input  logic                out_en_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                cpu_strb_n,
    input  logic                ctl_strb_n,
    input  logic                step_n,
    input  logic                all_wr_n,
    input  logic                lane_wr_en_n,
    input  logic [DATA_W/8-1:0] lane_sel_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);

    localparam int NB    = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic [NB-1:0]     byte_en;
    logic              wr_any;
    logic              ag_en, ag_load, ag_step;
    logic              do_rd, do_wr, awake;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_pend_q;
    logic              vld_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_q;
    logic              mem_we;

    burst_sram_lanes #(.NB(NB)) lanes_i (
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .byte_en      (byte_en),
        .wr_any       (wr_any)
    );

    burst_sram_fsm #(.WAKE_CYC(WAKE_CYC)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .cpu_strb_n (cpu_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .step_n     (step_n),
        .wr_any     (wr_any),
        .ag_en      (ag_en),
        .ag_load    (ag_load),
        .ag_step    (ag_step),
        .do_rd      (do_rd),
        .do_wr      (do_wr),
        .awake      (awake)
    );

    burst_sram_agen #(.ADDR_W(ADDR_W)) agen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ag_en),
        .load      (ag_load),
        .step      (ag_step),
        .lin_order (lin_order),
        .ext_addr  (addr),
        .cur_addr  (cur_addr)
    );

    assign mem_we = do_wr;

    // storage split per byte lane
    for (genvar g = 0; g < NB; g++) begin : g_mem
        logic [7:0] lane_q [DEPTH];
        always_ff @(posedge clk) begin
            if (mem_we && byte_en[g]) begin
                lane_q[cur_addr] <= wdata[8*g +: 8];
            end
        end
        assign rd_word[8*g +: 8] = lane_q[rd_addr_q];
    end

    // read pipeline: address stage then output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
            vld_q     <= 1'b0;
            dout_q    <= '0;
        end else begin
            rd_pend_q <= do_rd;
            if (do_rd) begin
                rd_addr_q <= cur_addr;
            end
            vld_q <= rd_pend_q && !sleep;
            if (rd_pend_q) begin
                dout_q <= rd_word;
            end
        end
    end

    assign rvalid = vld_q && !out_en_n;
    assign rdata  = rvalid ? dout_q : '0;

endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          out_en_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          cpu_strb_n,
    input logic          all_wr_n,
    input logic          lane_wr_en_n,
    input logic [NB-1:0] byte_en,
    input logic          mem_we,
    input logic          awake,
    input logic          rvalid
);

    AST_OE_MASKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rvalid); // R10

    AST_SLEEP_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rvalid); // R11

    AST_SLEEP_DROPS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !awake); // R11

    AST_WAKE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> (!$past(sleep, 1) && !$past(sleep, 2) && !$past(sleep, 3))); // R12

    AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !sleep && !sel_a_n && !cpu_strb_n) |-> !mem_we); // R4

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !sleep && !sel_a_n && !cpu_strb_n && !sel_b) |-> !mem_we); // R2

    AST_DESEL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !sleep && !sel_a_n && !cpu_strb_n && !sel_b) |=> ##1 !rvalid); // R2

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !all_wr_n |-> (&byte_en)); // R8

    AST_NO_LANE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && lane_wr_en_n) |-> (byte_en == '0)); // R8

endmodule

bind burst_sram burst_sram_chk #(.NB(NB)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .out_en_n     (out_en_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .cpu_strb_n   (cpu_strb_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .byte_en      (byte_en),
    .mem_we       (mem_we),
    .awake        (awake),
    .rvalid       (rvalid)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;
    localparam int M_DOWN  = 0;
    localparam int M_WAKE  = 1;
    localparam int M_IDLE  = 2;
    localparam int M_BURST = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep, lin_order, out_en_n;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          cpu_strb_n, ctl_strb_n, step_n;
    logic          all_wr_n, lane_wr_en_n;
    logic [3:0]    lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    int            ms;
    int            wc;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            prev_rd;
    logic [DW-1:0] prev_dat;

    always #2.5 clk = ~clk;

    burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .lin_order(lin_order),
        .out_en_n(out_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string tag, input logic av, input logic [DW-1:0] ad,
                         input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (av !== ev || ad !== ed) begin
            fails++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, av, ad, ev, ed);
        end
    endtask

    // reference model of one command edge
    task automatic model_cmd(output bit rd, output logic [DW-1:0] dat);
        bit sel, wr, do_w, do_r;
        logic [3:0] be;
        logic [1:0] lo;
        logic [AW-1:0] a;
        rd = 0; dat = '0; do_w = 0; do_r = 0;
        be  = !all_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_sel_n : 4'h0);
        wr  = |be;
        sel = !sel_a_n && sel_b && !sel_c_n;
        if (sleep) begin
            ms = M_DOWN;
        end else if (ms == M_DOWN) begin
            ms = M_WAKE; wc = 0;
        end else if (ms == M_WAKE) begin
            if (wc == 1) ms = M_IDLE; else wc++;
        end else begin
            if (!sel_a_n && !cpu_strb_n) begin
                if (sel) begin m_base = addr; m_cnt = 0; ms = M_BURST; do_r = 1; end
                else ms = M_IDLE;
            end else if (!ctl_strb_n) begin
                if (sel) begin m_base = addr; m_cnt = 0; ms = M_BURST; do_w = wr; do_r = !wr; end
                else ms = M_IDLE;
            end else if (ms == M_BURST) begin
                if (!step_n) m_cnt = m_cnt + 2'd1;
                do_w = wr; do_r = !wr;
            end
            lo = lin_order ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
            a  = {m_base[AW-1:2], lo};
            if (do_w) begin
                for (int i = 0; i < 4; i++)
                    if (be[i]) ref_mem[a][8*i +: 8] = wdata[8*i +: 8];
            end
            if (do_r) begin rd = 1; dat = ref_mem[a]; end
        end
    endtask

    // one command: drive (already set), edge, check result of command two back
    task automatic step(input string tag);
        bit nr;
        logic [DW-1:0] nd;
        bit ev;
        logic [DW-1:0] ed;
        model_cmd(nr, nd);
        @(posedge clk);
        @(negedge clk);
        ev = prev_rd && !sleep && !out_en_n;
        ed = ev ? prev_dat : '0;
        check(tag, rvalid, rdata, ev, ed);
        prev_rd  = nr;
        prev_dat = nd;
    endtask

    task automatic idle_fields();
        sleep = 0; out_en_n = 0;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1;
        all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
    endtask

    task automatic ctl_cmd(input logic [AW-1:0] a, input bit wr, input logic [3:0] bw,
                           input logic [DW-1:0] d, input string tag);
        idle_fields();
        ctl_strb_n = 0; addr = a; wdata = d;
        if (wr) begin lane_wr_en_n = 0; lane_sel_n = bw; end
        step(tag);
    endtask

    task automatic cpu_cmd(input logic [AW-1:0] a, input string tag);
        idle_fields();
        cpu_strb_n = 0; addr = a;
        step(tag);
    endtask

    task automatic cont_cmd(input bit adv, input bit wr, input logic [DW-1:0] d,
                            input string tag);
        idle_fields();
        step_n = !adv; wdata = d;
        if (wr) all_wr_n = 0;
        step(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        ms = M_IDLE; wc = 0; m_base = '0; m_cnt = '0;
        prev_rd = 0; prev_dat = '0;
        idle_fields();
        lin_order = 1; addr = '0; wdata = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1", rvalid, rdata, 1'b0, '0);
        // R1: step cycle with no burst open returns nothing
        cont_cmd(1, 0, '0, "R1");
        cont_cmd(0, 0, '0, "R1");

        // R5: fill through controller-strobe writes
        for (int a = 0; a < DEPTH; a++) ctl_cmd(AW'(a), 1, 4'h0, $urandom, "R5");
        ctl_cmd(6'd5, 0, 4'hF, '0, "R5");
        cont_cmd(1, 0, '0, "R9");

        // R4: processor start reads even with global write low, then late write
        idle_fields(); cpu_strb_n = 0; addr = 6'd9; all_wr_n = 0; wdata = 32'hDEAD_BEEF;
        step("R4");
        cont_cmd(0, 1, 32'h1234_5678, "R4");
        cont_cmd(1, 1, 32'h0BAD_F00D, "R4");
        ctl_cmd(6'd9, 0, 4'hF, '0, "R4");
        ctl_cmd(6'd10, 0, 4'hF, '0, "R4");

        // R7: linear from low bits 2, interleaved from low bits 1
        lin_order = 1;
        cpu_cmd(6'd6, "R7");
        for (int i = 0; i < 4; i++) cont_cmd(1, 0, '0, "R7");
        lin_order = 0;
        cpu_cmd(6'd13, "R7");
        for (int i = 0; i < 4; i++) cont_cmd(1, 0, '0, "R7");

        // R6: suspend on read and on write
        lin_order = 1;
        ctl_cmd(6'd20, 0, 4'hF, '0, "R6");
        cont_cmd(0, 0, '0, "R6");
        cont_cmd(0, 0, '0, "R6");
        cont_cmd(1, 0, '0, "R6");
        ctl_cmd(6'd20, 1, 4'h0, 32'hAAAA_0001, "R6");
        cont_cmd(0, 1, 32'hAAAA_0002, "R6");
        cont_cmd(1, 1, 32'hAAAA_0003, "R6");
        ctl_cmd(6'd20, 0, 4'hF, '0, "R6");
        cont_cmd(1, 0, '0, "R6");
        cont_cmd(1, 0, '0, "R6");

        // R8: lane masks and global override
        ctl_cmd(6'd30, 1, 4'b0101, 32'h11_22_33_44, "R8");
        ctl_cmd(6'd30, 0, 4'hF, '0, "R8");
        idle_fields(); ctl_strb_n = 0; addr = 6'd31; all_wr_n = 0; wdata = 32'hCAFE_0031;
        step("R8");
        ctl_cmd(6'd31, 0, 4'hF, '0, "R8");
        idle_fields(); ctl_strb_n = 0; addr = 6'd32; lane_sel_n = 4'h0; wdata = 32'h5555_5555;
        step("R8");
        cont_cmd(0, 0, '0, "R8");

        // R2: bad selects deselect and close the burst
        idle_fields(); cpu_strb_n = 0; addr = 6'd3; sel_b = 0;
        step("R2");
        cont_cmd(1, 0, '0, "R2");
        cont_cmd(1, 1, 32'h7777_7777, "R2");
        idle_fields(); ctl_strb_n = 0; addr = 6'd4; sel_c_n = 1; all_wr_n = 0; wdata = 32'h6666_6666;
        step("R2");
        ctl_cmd(6'd4, 0, 4'hF, '0, "R2");
        cont_cmd(0, 0, '0, "R2");

        // R3: processor strobe ignored while sel_a_n high
        cpu_cmd(6'd40, "R3");
        idle_fields(); sel_a_n = 1; cpu_strb_n = 0; step_n = 0;
        step("R3");
        idle_fields(); sel_a_n = 1; cpu_strb_n = 0; step_n = 1;
        step("R3");
        cont_cmd(0, 0, '0, "R3");

        // R10: output enable masks a due read
        ctl_cmd(6'd5, 0, 4'hF, '0, "R10");
        idle_fields(); out_en_n = 1;
        step("R10");
        cont_cmd(0, 0, '0, "R10");

        // R11: sleep drops a due read and ignores writes
        ctl_cmd(6'd50, 1, 4'h0, 32'h5050_5050, "R11");
        ctl_cmd(6'd50, 0, 4'hF, '0, "R11");
        idle_fields(); sleep = 1; ctl_strb_n = 0; addr = 6'd50; all_wr_n = 0; wdata = 32'hBAD0_0050;
        step("R11");
        step("R11");
        // R12: three ignored edges, then accepted
        for (int i = 0; i < 3; i++) ctl_cmd(6'd50, 1, 4'h0, 32'hBAD1_0050, "R12");
        ctl_cmd(6'd50, 0, 4'hF, '0, "R12");
        cont_cmd(0, 0, '0, "R12");
        cont_cmd(0, 0, '0, "R12");

        // R9: constrained random traffic
        begin
            int sleep_left = 0;
            for (int n = 0; n < 2500; n++) begin
                idle_fields();
                if (sleep_left > 0) begin
                    sleep = 1; sleep_left--;
                end else if ($urandom % 100 == 0) begin
                    sleep = 1; sleep_left = $urandom % 4;
                end
                sel_a_n      = ($urandom % 10 == 0);
                sel_b        = ($urandom % 10 != 0);
                sel_c_n      = ($urandom % 10 == 0);
                cpu_strb_n   = ($urandom % 4 != 0);
                ctl_strb_n   = ($urandom % 4 != 0);
                step_n       = $urandom % 2;
                all_wr_n     = ($urandom % 8 != 0);
                lane_wr_en_n = ($urandom % 3 == 0);
                lane_sel_n   = 4'($urandom);
                out_en_n     = ($urandom % 12 == 0);
                lin_order    = $urandom % 2;
                addr         = AW'($urandom);
                wdata        = $urandom;
                step("R9");
            end
        end
        idle_fields();
        step("R9");
        step("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule